// File: doc/BRIEF.md
# Wrapping Multi-Word Register File

This block is a 16-bit register file with two read ports and one write port. It holds two banks. The user bank has sixteen entries, R0 to R15. A second bank of eight scratch entries can be reached only when a port raises its microcode bank select. Wide operands are addressed by the register that holds their most significant word. A double-precision operand spans two registers and an extended-precision operand spans three.

Every port takes a base index, a word offset of 0 to 2 and a bank select. A datapath moves a wide operand 16 bits per cycle by stepping the offset from 0 upward while the base stays fixed. In the user bank the effective index is computed modulo sixteen, so R15 continues into R0 and then R1. In the microcode bank an index never wraps back into the user bank. Instead, an index past the end of that bank, or an offset of 3, raises the port's error flag.

Reads are combinational. A write lands on the clock edge, so new data can be read in the following cycle. A read in the same cycle as the write returns the previous contents.

Top module: `wide_operand_regfile`

## Requirements
- R1: After reset every entry of both banks reads as zero.
- R2: With bank select low and offset 0 to 2, a read port returns user entry (base + offset) mod 16.
- R3: User indexing wraps inside the user bank: base 15 with offset 1 reaches R0, and base 15 with offset 2 or base 14 with offset 2 reaches R1 or R0. No user-bank address reaches a microcode-bank entry.
- R4: With bank select high, offset 0 to 2 and base + offset below 8, a port addresses microcode entry base + offset. This entry is separate from every user entry.
- R5: A port's error flag is 1 when its offset is 3, or when bank select is high and base + offset is 8 or more. Otherwise the flag is 0. A read port with its error flag set returns zero.
- R6: A write with wr_en high and wr_err low stores wr_data at the entry chosen by the same base-plus-offset rule as the read ports. A write with wr_err high, or with wr_en low, changes no entry.
- R7: Written data is visible on a read port in the cycle after the write edge. A read of the same entry in the cycle of the write returns the old value, because there is no bypass.
- R8: Both read ports work at the same time and each one uses only its own address inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| wr_en | input | 1 | Write request |
| wr_base | input | 4 | Write base index (most significant word) |
| wr_off | input | 2 | Write word offset |
| wr_micro | input | 1 | Write bank select, 1 = microcode bank |
| wr_data | input | 16 | Write data |
| wr_err | output | 1 | Write address invalid; write suppressed |
| rda_base | input | 4 | Read port A base index |
| rda_off | input | 2 | Read port A word offset |
| rda_micro | input | 1 | Read port A bank select |
| rda_data | output | 16 | Read port A data |
| rda_err | output | 1 | Read port A address invalid |
| rdb_base | input | 4 | Read port B base index |
| rdb_off | input | 2 | Read port B word offset |
| rdb_micro | input | 1 | Read port B bank select |
| rdb_data | output | 16 | Read port B data |
| rdb_err | output | 1 | Read port B address invalid |

## Verification
The bench builds the block with its default parameters: 16 user entries, 8 microcode entries and a maximum offset of 2. This size is small enough that every combination of base, offset and bank select can be swept on both read ports after each phase of the test. The sweep covers every wrap case, every out-of-bank microcode index and the reserved offset. The bench first fills all 24 entries through the offset path and then sweeps the whole address space. Because the model is a flat 24-entry array, any stray or suppressed write becomes visible as a mismatch.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    typedef enum logic {
        BANK_USER  = 1'b0,
        BANK_MICRO = 1'b1
    } bank_e;

    localparam int DEF_WORD_W     = 16;
    localparam int DEF_USER_REGS  = 16;
    localparam int DEF_MICRO_REGS = 8;
    localparam int DEF_MAX_OFF    = 2;

endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int USER_REGS  = DEF_USER_REGS,
    parameter int MICRO_REGS = DEF_MICRO_REGS,
    parameter int MAX_OFF    = DEF_MAX_OFF,
    localparam int UIDX_W    = $clog2(USER_REGS),
    localparam int OFF_W     = $clog2(MAX_OFF + 2),
    localparam int PHYS_W    = $clog2(USER_REGS + MICRO_REGS)
) (
    input  logic [UIDX_W-1:0] base_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              micro_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic              err_o
);

    localparam int SUM_W = UIDX_W + OFF_W + 1;

    logic [SUM_W-1:0] sum_d;
    logic [SUM_W-1:0] wrapped_d;

    always_comb begin
        sum_d     = SUM_W'(base_i) + SUM_W'(off_i);
        wrapped_d = sum_d % SUM_W'(USER_REGS);
        err_o     = 1'b0;
        phys_o    = '0;
        if (int'(off_i) > MAX_OFF) begin
            err_o = 1'b1;
        end else if (bank_e'(micro_i) == BANK_MICRO) begin
            if (int'(sum_d) >= MICRO_REGS) begin
                err_o = 1'b1;
            end else begin
                phys_o = PHYS_W'(USER_REGS) + PHYS_W'(sum_d);
            end
        end else begin
            phys_o = PHYS_W'(wrapped_d);
        end
    end

    always_comb begin
        if (!err_o && micro_i) begin
            a_r4_micro_hi: assert (int'(phys_o) >= USER_REGS);
        end
        if (!err_o && !micro_i) begin
            a_r3_user_low: assert (int'(phys_o) < USER_REGS);
        end
        if (int'(off_i) > MAX_OFF) begin
            a_r5_bad_offset: assert (err_o);
        end
    end

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int WORD_W  = 16,
    parameter int ENTRIES = 24,
    parameter int NUM_RD  = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [IDX_W-1:0]             widx_i,
    input  logic [WORD_W-1:0]            wdata_i,
    input  logic [NUM_RD-1:0][IDX_W-1:0] ridx_i,
    input  logic [NUM_RD-1:0]            rerr_i,
    output logic [NUM_RD-1:0][WORD_W-1:0] rdata_o
);

    typedef struct packed {
        logic [ENTRIES-1:0][WORD_W-1:0] regs;
    } store_t;

    store_t st_d;
    store_t st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && int'(widx_i) < ENTRIES) begin
            st_d.regs[widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            if (rerr_i[p] || int'(ridx_i[p]) >= ENTRIES) begin
                rdata_o[p] = '0;
            end else begin
                rdata_o[p] = st_q.regs[ridx_i[p]];
            end
        end
    end

    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we_i) && int'($past(widx_i)) < ENTRIES)
            |-> st_q.regs[$past(widx_i)] == $past(wdata_i));

    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(we_i)) |-> st_q == $past(st_q));

endmodule

// File: rtl/wide_operand_regfile.sv
module wide_operand_regfile
    import wrf_pkg::*;
#(
    parameter int WORD_W     = DEF_WORD_W,
    parameter int USER_REGS  = DEF_USER_REGS,
    parameter int MICRO_REGS = DEF_MICRO_REGS,
    parameter int MAX_OFF    = DEF_MAX_OFF,
    localparam int UIDX_W    = $clog2(USER_REGS),
    localparam int OFF_W     = $clog2(MAX_OFF + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [UIDX_W-1:0] wr_base,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic              wr_micro,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_err,
    input  logic [UIDX_W-1:0] rda_base,
    input  logic [OFF_W-1:0]  rda_off,
    input  logic              rda_micro,
    output logic [WORD_W-1:0] rda_data,
    output logic              rda_err,
    input  logic [UIDX_W-1:0] rdb_base,
    input  logic [OFF_W-1:0]  rdb_off,
    input  logic              rdb_micro,
    output logic [WORD_W-1:0] rdb_data,
    output logic              rdb_err
);

    localparam int ENTRIES = USER_REGS + MICRO_REGS;
    localparam int PHYS_W  = $clog2(ENTRIES);
    localparam int NUM_RD  = 2;

    logic [NUM_RD-1:0][UIDX_W-1:0] rd_base;
    logic [NUM_RD-1:0][OFF_W-1:0]  rd_off;
    logic [NUM_RD-1:0]             rd_micro;
    logic [NUM_RD-1:0][PHYS_W-1:0] rd_phys;
    logic [NUM_RD-1:0]             rd_err;
    logic [NUM_RD-1:0][WORD_W-1:0] rd_data;
    logic [PHYS_W-1:0]             wr_phys;
    logic                          store_we;

    assign rd_base  = {rdb_base, rda_base};
    assign rd_off   = {rdb_off, rda_off};
    assign rd_micro = {rdb_micro, rda_micro};

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rmap
        wrf_addr_map #(
            .USER_REGS (USER_REGS),
            .MICRO_REGS(MICRO_REGS),
            .MAX_OFF   (MAX_OFF)
        ) u_map (
            .base_i (rd_base[p]),
            .off_i  (rd_off[p]),
            .micro_i(rd_micro[p]),
            .phys_o (rd_phys[p]),
            .err_o  (rd_err[p])
        );
    end

    wrf_addr_map #(
        .USER_REGS (USER_REGS),
        .MICRO_REGS(MICRO_REGS),
        .MAX_OFF   (MAX_OFF)
    ) u_wmap (
        .base_i (wr_base),
        .off_i  (wr_off),
        .micro_i(wr_micro),
        .phys_o (wr_phys),
        .err_o  (wr_err)
    );

    assign store_we = wr_en && !wr_err;

    wrf_storage #(
        .WORD_W (WORD_W),
        .ENTRIES(ENTRIES),
        .NUM_RD (NUM_RD)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (store_we),
        .widx_i (wr_phys),
        .wdata_i(wr_data),
        .ridx_i (rd_phys),
        .rerr_i (rd_err),
        .rdata_o(rd_data)
    );

    assign rda_data = rd_data[0];
    assign rdb_data = rd_data[1];
    assign rda_err  = rd_err[0];
    assign rdb_err  = rd_err[1];

endmodule

// File: tb/wide_operand_regfile_bench.sv
`timescale 1ns/1ps
module wide_operand_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_base = '0;
    logic [1:0]  wr_off = '0;
    logic        wr_micro = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_err;
    logic [3:0]  rda_base = '0;
    logic [1:0]  rda_off = '0;
    logic        rda_micro = 1'b0;
    logic [15:0] rda_data;
    logic        rda_err;
    logic [3:0]  rdb_base = '0;
    logic [1:0]  rdb_off = '0;
    logic        rdb_micro = 1'b0;
    logic [15:0] rdb_data;
    logic        rdb_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] model [24];

    always #2 clk = ~clk;

    wide_operand_regfile u_wide_operand_regfile (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_base(wr_base), .wr_off(wr_off), .wr_micro(wr_micro),
        .wr_data(wr_data), .wr_err(wr_err),
        .rda_base(rda_base), .rda_off(rda_off), .rda_micro(rda_micro),
        .rda_data(rda_data), .rda_err(rda_err),
        .rdb_base(rdb_base), .rdb_off(rdb_off), .rdb_micro(rdb_micro),
        .rdb_data(rdb_data), .rdb_err(rdb_err)
    );

    // Target entry from the requirements: -1 marks an invalid address (R5).
    function automatic int target(int b, int o, bit m);
        if (o > 2) return -1;
        if (m) return (b + o >= 8) ? -1 : 16 + b + o;
        return (b + o) % 16;
    endfunction

    task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sweep(string req);
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 16; b++) begin
                for (int o = 0; o < 4; o++) begin
                    int ta;
                    int tb;
                    int bb;
                    int ob;
                    bb = b ^ 10;
                    ob = (o + 1) % 4;
                    rda_base = 4'(b); rda_off = 2'(o); rda_micro = m[0];
                    rdb_base = 4'(bb); rdb_off = 2'(ob); rdb_micro = m[0];
                    #0.5;
                    ta = target(b, o, m[0]);
                    tb = target(bb, ob, m[0]);
                    chk(req, {rda_err, rda_data},
                        (ta < 0) ? {1'b1, 16'h0} : {1'b0, model[ta]});
                    chk({req, " R8 port B"}, {rdb_err, rdb_data},
                        (tb < 0) ? {1'b1, 16'h0} : {1'b0, model[tb]});
                end
            end
        end
    endtask

    task automatic do_write(bit en, int b, int o, bit m, logic [15:0] d);
        int t;
        @(negedge clk);
        wr_en = en; wr_base = 4'(b); wr_off = 2'(o); wr_micro = m; wr_data = d;
        #0.5;
        t = target(b, o, m);
        chk("R5 write error flag", {16'h0, wr_err}, {16'h0, t < 0});
        @(negedge clk);
        wr_en = 1'b0;
        if (en && t >= 0) model[t] = d;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 24; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all entries zero after reset
        sweep("R1 reset");

        // R2 R3 R4 R6: fill every entry via the offset path
        for (int t = 0; t < 16; t++)
            do_write(1'b1, (t - (t % 3) + 16) % 16, t % 3, 1'b0, 16'hA000 ^ 16'(t * 16'h0137));
        for (int t = 0; t < 8; t++)
            do_write(1'b1, t - (t % 3), t % 3, 1'b1, 16'h5C00 ^ 16'(t * 16'h0241));
        sweep("R2 R4 R6 fill");

        // R3: wrapped writes from R15 land in R0 and R1
        do_write(1'b1, 15, 1, 1'b0, 16'h1111);
        do_write(1'b1, 15, 2, 1'b0, 16'h2222);
        do_write(1'b1, 14, 2, 1'b0, 16'h3333);
        sweep("R3 wrap");

        // R5 R6: invalid or disabled writes change nothing
        do_write(1'b1, 6, 2, 1'b1, 16'hFFFF);
        do_write(1'b1, 7, 1, 1'b1, 16'hFFFF);
        do_write(1'b1, 12, 0, 1'b1, 16'hFFFF);
        do_write(1'b1, 3, 3, 1'b0, 16'hFFFF);
        do_write(1'b1, 0, 3, 1'b1, 16'hFFFF);
        do_write(1'b0, 5, 0, 1'b0, 16'hFFFF);
        do_write(1'b0, 2, 0, 1'b1, 16'hFFFF);
        sweep("R6 suppressed");

        // R7: no same-cycle bypass, visible next cycle
        @(negedge clk);
        rda_base = 4'd4; rda_off = 2'd1; rda_micro = 1'b0;
        rdb_base = 4'd6; rdb_off = 2'd1; rdb_micro = 1'b1;
        wr_en = 1'b1; wr_base = 4'd3; wr_off = 2'd2; wr_micro = 1'b0; wr_data = 16'hBEEF;
        #0.5;
        chk("R7 same-cycle old value", {rda_err, rda_data}, {1'b0, model[5]});
        @(posedge clk);
        #0.5;
        wr_en = 1'b0;
        model[5] = 16'hBEEF;
        chk("R7 next-cycle new value", {rda_err, rda_data}, {1'b0, 16'hBEEF});
        chk("R8 port B untouched", {rdb_err, rdb_data}, {1'b0, model[23]});
        @(negedge clk);
        sweep("R7 final");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule